// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block is a built-in self-test sequencer for one synchronous single-port SRAM. A one-cycle start pulse launches the six-element March C- algorithm. The block then drives the memory address, write enable, write data and read strobe with one operation per clock and no idle cycles. The run takes 10N cycles for N words. Every read result is checked against the data background that the previous element left in the array. The first mismatch is latched: its address, its element index and the bits that differ. The test always runs to the end, then raises `done_o` and shows the verdict.

The address is split into a word-line (row) field and a column field. The walk is word-line-major in both directions, so every word of a row is visited before the walk moves to the next row. Every access to a row also stresses the other cells on that row the way a read would. This exposes slow-recovering cells, which are dynamic read-destructive, and it costs no extra operations.

A finished test can be started again without reset. The memory port stays quiet while the verdict is held.

Top module: `mbist_march_ctrl`

## Requirements
- R1: A start pulse accepted while idle or done launches a run. The first operation appears on the memory port in the second cycle after the start cycle. `fail_o` and `done_o` are low from the cycle after the start cycle.
- R2: The run issues exactly 10N operations, one per cycle with no gaps, in this order. Element 0 writes 0 ascending. Element 1 does (read 0, write 1) ascending. Element 2 does (read 1, write 0) ascending. Element 3 does (read 0, write 1) descending. Element 4 does (read 1, write 0) descending. Element 5 reads 0 ascending.
- R3: `mem_addr_o` = {row, column}, with the column in the low COL_W bits. Ascending order steps the column first and carries into the row. Descending order is the exact reverse.
- R4: A read and a write never occur in the same cycle. Write data is all zeros or all ones.
- R5: Read data is sampled on `mem_rdata_i` one cycle after the cycle in which `mem_re_o` was high. It is compared with all-zeros or all-ones, whichever the element expects.
- R6: On the first mismatch of a run, `fail_o` rises and the block latches the address, the element index (0 to 5, 3 bits) and the mask of differing bits (read XOR expected). Later mismatches leave the latched values unchanged.
- R7: After a mismatch the run continues to the end. `done_o` rises two cycles after the last operation is shown on the port. `pass_o` = `done_o` and not `fail_o`.
- R8: While `done_o` is high, `mem_we_o` and `mem_re_o` are low. A start pulse during a run has no effect on the operation stream.
- R9: A start pulse while done clears the previous verdict and repeats the full run without reset.
- R10: During and after synchronous active-high reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the test |
| mem_addr_o | output | ROW_W+COL_W | Memory word address {row, column} |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the strobe |
| done_o | output | 1 | Test finished, verdict valid |
| pass_o | output | 1 | Finished with no mismatch |
| fail_o | output | 1 | A mismatch was seen in this run |
| fail_addr_o | output | ROW_W+COL_W | Address of the first mismatch |
| fail_elem_o | output | 3 | Element index (0 to 5) of the first mismatch |
| fail_mask_o | output | DATA_W | Differing bits of the first mismatch |

## Verification
The assertions check these on every cycle: read and write never overlap, write data stays a uniform background, the port stays quiet while done, the element index stays in range, the row carry and borrow of the address walk are correct, and the first-failure record stays frozen until the next start. Other behaviour needs the bench's scenarios. These are the exact 10N operation stream with its address order, the one-cycle read-compare alignment, the element index reported for faults first seen on the ascending or descending pass, keeping only the first of two faults, ignoring a start pulse during a run, and repeating a run after a failure without reset.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int NUM_ELEM  = 6;
  localparam int ELEM_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } bist_state_e;

  // two_op : element is a read followed by a write per address
  // down   : descending address walk
  // first_rd : first (or only) operation is a read
  // bg     : background read (or written by a single-write element)
  typedef struct packed {
    logic two_op;
    logic down;
    logic first_rd;
    logic bg;
  } elem_cfg_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic bit_val;
  } mem_op_t;

  function automatic elem_cfg_t elem_cfg(input logic [ELEM_W-1:0] e);
    elem_cfg_t c;
    case (e)
      3'd0:    c = '{two_op: 1'b0, down: 1'b0, first_rd: 1'b0, bg: 1'b0};
      3'd1:    c = '{two_op: 1'b1, down: 1'b0, first_rd: 1'b1, bg: 1'b0};
      3'd2:    c = '{two_op: 1'b1, down: 1'b0, first_rd: 1'b1, bg: 1'b1};
      3'd3:    c = '{two_op: 1'b1, down: 1'b1, first_rd: 1'b1, bg: 1'b0};
      3'd4:    c = '{two_op: 1'b1, down: 1'b1, first_rd: 1'b1, bg: 1'b1};
      default: c = '{two_op: 1'b0, down: 1'b0, first_rd: 1'b1, bg: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ROW_W = 9,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic                   down_i,
  input  logic                   step_i,
  output logic [ROW_W+COL_W-1:0] addr_o,
  output logic                   last_o
);

  localparam logic [ROW_W-1:0] ROW_MAX = '1;
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
      dir_q <= 1'b0;
    end else if (load_i) begin
      row_q <= down_i ? ROW_MAX : '0;
      col_q <= down_i ? COL_MAX : '0;
      dir_q <= down_i;
    end else if (step_i) begin
      if (!dir_q) begin
        col_q <= col_q + 1'b1;
        if (col_q == COL_MAX) row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q - 1'b1;
        if (col_q == '0) row_q <= row_q - 1'b1;
      end
    end
  end

  assign addr_o = {row_q, col_q};
  assign last_o = dir_q ? (row_q == '0 && col_q == '0)
                        : (row_q == ROW_MAX && col_q == COL_MAX);

  // R3: finishing a word line ascending moves to column 0 of the next row
  a_r3_row_carry: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && !dir_q && col_q == COL_MAX)
      |=> (col_q == '0 && row_q == $past(row_q) + 1'b1));

  // R3: descending walk borrows from the row after column 0
  a_r3_row_borrow: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && dir_q && col_q == '0)
      |=> (col_q == COL_MAX && row_q == $past(row_q) - 1'b1));

endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_last_i,
  output mem_op_t           op_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              load_o,
  output logic              down_o,
  output logic              step_o,
  output logic              clear_o,
  output logic              done_o
);

  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

  bist_state_e       state_q;
  logic [ELEM_W-1:0] elem_q;
  logic [ELEM_W-1:0] elem_nxt;
  logic              phase_q;
  logic              drain_q;
  elem_cfg_t         cfg;
  elem_cfg_t         cfg_nxt;
  logic              start_ok;
  logic              addr_done;
  logic              elem_end;
  logic              run_end;

  assign cfg       = elem_cfg(elem_q);
  assign elem_nxt  = elem_q + 1'b1;
  assign cfg_nxt   = elem_cfg(elem_nxt);
  assign start_ok  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign addr_done = (state_q == ST_RUN) && (!cfg.two_op || phase_q);
  assign elem_end  = addr_done && addr_last_i;
  assign run_end   = elem_end && (elem_q == LAST_ELEM);

  always_comb begin
    op_o = '0;
    if (state_q == ST_RUN) begin
      if (cfg.two_op) begin
        if (!phase_q) begin
          op_o.rd      = 1'b1;
          op_o.bit_val = cfg.bg;
        end else begin
          op_o.wr      = 1'b1;
          op_o.bit_val = ~cfg.bg;
        end
      end else begin
        op_o.rd      = cfg.first_rd;
        op_o.wr      = ~cfg.first_rd;
        op_o.bit_val = cfg.bg;
      end
    end
  end

  assign load_o  = start_ok || (elem_end && !run_end);
  assign down_o  = start_ok ? 1'b0 : cfg_nxt.down;
  assign step_o  = addr_done && !addr_last_i;
  assign clear_o = start_ok;
  assign elem_o  = elem_q;
  assign done_o  = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      phase_q <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state_q <= ST_RUN;
            elem_q  <= '0;
            phase_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (cfg.two_op) phase_q <= ~phase_q;
          if (run_end) begin
            state_q <= ST_DRAIN;
            drain_q <= 1'b0;
          end else if (elem_end) begin
            elem_q  <= elem_nxt;
            phase_q <= 1'b0;
          end
        end
        default: begin
          if (drain_q) state_q <= ST_DONE;
          drain_q <= 1'b1;
        end
      endcase
    end
  end

  // R2: element index never leaves 0..5
  a_r2_elem_range: assert property (@(posedge clk) disable iff (rst)
    elem_q <= LAST_ELEM);

  // R8: a running test keeps running whatever start does, until its last op
  a_r8_run_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !run_end) |=> (state_q == ST_RUN));

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int ELEM_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              exp_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [DATA_W-1:0] fail_mask_o
);

  logic              p_vld_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic              p_exp_q;
  logic [ELEM_W-1:0] p_elem_q;
  logic [DATA_W-1:0] diff;

  assign diff = rdata_i ^ {DATA_W{p_exp_q}};

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld_q  <= 1'b0;
      p_addr_q <= '0;
      p_exp_q  <= 1'b0;
      p_elem_q <= '0;
    end else begin
      p_vld_q  <= rd_i;
      p_addr_q <= addr_i;
      p_exp_q  <= exp_i;
      p_elem_q <= elem_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
      fail_mask_o <= '0;
    end else if (p_vld_q && (diff != '0) && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= p_addr_q;
      fail_elem_o <= p_elem_q;
      fail_mask_o <= diff;
    end
  end

  // R6: once latched, the first-failure record is frozen until cleared
  a_r6_first_kept: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !clear_i) |=> (fail_o && $stable(fail_addr_o) &&
                              $stable(fail_elem_o) && $stable(fail_mask_o)));

  // R6: a latched failure always names at least one differing bit
  a_r6_mask_set: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (fail_mask_o != '0));

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
  import march_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  output logic [ROW_W+COL_W-1:0] mem_addr_o,
  output logic                   mem_we_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  output logic                   mem_re_o,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   done_o,
  output logic                   pass_o,
  output logic                   fail_o,
  output logic [ROW_W+COL_W-1:0] fail_addr_o,
  output logic [2:0]             fail_elem_o,
  output logic [DATA_W-1:0]      fail_mask_o
);

  localparam int ADDR_W = ROW_W + COL_W;

  mem_op_t           op;
  logic [ELEM_W-1:0] elem;
  logic              ag_load;
  logic              ag_down;
  logic              ag_step;
  logic              ag_last;
  logic [ADDR_W-1:0] ag_addr;
  logic              clear;
  logic              exp_q;
  logic [ELEM_W-1:0] elem_q;

  march_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .addr_last_i (ag_last),
    .op_o        (op),
    .elem_o      (elem),
    .load_o      (ag_load),
    .down_o      (ag_down),
    .step_o      (ag_step),
    .clear_o     (clear),
    .done_o      (done_o)
  );

  march_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load_i (ag_load),
    .down_i (ag_down),
    .step_i (ag_step),
    .addr_o (ag_addr),
    .last_o (ag_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
      mem_wdata_o <= '0;
      exp_q       <= 1'b0;
      elem_q      <= '0;
    end else begin
      mem_addr_o  <= ag_addr;
      mem_we_o    <= op.wr;
      mem_re_o    <= op.rd;
      mem_wdata_o <= op.wr ? {DATA_W{op.bit_val}} : '0;
      exp_q       <= op.bit_val;
      elem_q      <= elem;
    end
  end

  march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (clear),
    .rd_i        (mem_re_o),
    .addr_i      (mem_addr_o),
    .exp_i       (exp_q),
    .elem_i      (elem_q),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_elem_o (fail_elem_o),
    .fail_mask_o (fail_mask_o)
  );

  assign pass_o = done_o && !fail_o;

  // R4: the port never reads and writes at once
  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));

  // R4: write data is a uniform background
  a_r4_wdata_bg: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));

  // R8: no memory traffic while the verdict is held
  a_r8_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_we_o && !mem_re_o));

endmodule

// File: tb/mbist_march_ctrl_bench.sv
module mbist_march_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3;
  localparam int COL_W = 2;
  localparam int DW    = 8;
  localparam int AW    = ROW_W + COL_W;
  localparam int COLS  = 1 << COL_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int NW    = ROWS * COLS;
  localparam int NOPS  = 10 * NW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic          mem_re;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;
  logic [DW-1:0] fail_mask;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbist_march_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW)) u_mbist_march_ctrl (
    .clk(clk), .rst(rst), .start_i(start),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .done_o(done), .pass_o(pass), .fail_o(fail),
    .fail_addr_o(fail_addr), .fail_elem_o(fail_elem), .fail_mask_o(fail_mask)
  );

  // fault set: type 0 stuck-at-0, 1 stuck-at-1, 2 cannot fall 1->0
  logic f_en   [2];
  int   f_addr [2];
  int   f_bit  [2];
  int   f_type [2];

  function automatic logic [DW-1:0] faulty_write(int a, logic [DW-1:0] old_v,
                                                 logic [DW-1:0] new_v);
    logic [DW-1:0] r = new_v;
    for (int f = 0; f < 2; f++) begin
      if (f_en[f] && f_addr[f] == a) begin
        if (f_type[f] == 0) r[f_bit[f]] = 1'b0;
        else if (f_type[f] == 1) r[f_bit[f]] = 1'b1;
        else if (old_v[f_bit[f]] === 1'b1) r[f_bit[f]] = 1'b1;
      end
    end
    return r;
  endfunction

  // bench memory: synchronous read, one cycle latency
  logic [DW-1:0] mem [NW];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= faulty_write(int'(mem_addr), mem[mem_addr], mem_wdata);
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // reference operation stream
  logic          e_we [NOPS];
  logic          e_re [NOPS];
  int            e_addr [NOPS];
  logic [DW-1:0] e_wd [NOPS];
  logic          x_fail;
  int            x_faddr;
  int            x_felem;
  logic [DW-1:0] x_fmask;
  logic [DW-1:0] shadow [NW];

  task automatic build_ref();
    int k = 0;
    x_fail = 1'b0; x_faddr = 0; x_felem = 0; x_fmask = '0;
    for (int e = 0; e < 6; e++) begin
      bit down = (e == 3 || e == 4);
      bit bg   = (e == 2 || e == 4);
      for (int i = 0; i < NW; i++) begin
        int idx = down ? (NW - 1 - i) : i;
        int a   = (idx / COLS) * COLS + (idx % COLS);  // {row, col}
        int nops = (e == 0 || e == 5) ? 1 : 2;
        for (int p = 0; p < nops; p++) begin
          bit is_rd = (e == 5) || (e != 0 && p == 0);
          logic [DW-1:0] bgw = bg ? '1 : '0;
          e_addr[k] = a;
          e_re[k]   = is_rd;
          e_we[k]   = !is_rd;
          e_wd[k]   = is_rd ? '0 : ((e == 0) ? '0 : ~bgw);
          if (is_rd) begin
            if (shadow[a] !== bgw && !x_fail) begin
              x_fail = 1'b1; x_faddr = a; x_felem = e; x_fmask = shadow[a] ^ bgw;
            end
          end else begin
            shadow[a] = faulty_write(a, shadow[a], e_wd[k]);
          end
          k++;
        end
      end
    end
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_test(bit mid_start, int fl_ok);
    build_ref();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R1: verdict cleared, no op yet in the cycle after start
    chk(!fail && !done, "R1/R9 verdict cleared after start", {fail, done}, 0);
    chk(!mem_we && !mem_re, "R1 no op before second cycle", {mem_we, mem_re}, 0);
    for (int k = 0; k < NOPS; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(mem_we == e_we[k] && mem_re == e_re[k], "R2 op kind",
          {mem_we, mem_re}, {e_we[k], e_re[k]});
      chk(int'(mem_addr) == e_addr[k], "R3 address order", mem_addr, e_addr[k]);
      if (e_we[k]) chk(mem_wdata == e_wd[k], "R4 write background", mem_wdata, e_wd[k]);
      if (mid_start && k == 40) start = 1'b1;  // R8 ignored while running
    end
    start = 1'b0;
    @(negedge clk);
    chk(!mem_we && !mem_re && !done, "R7 drain cycle", {mem_we, mem_re, done}, 0);
    @(negedge clk);
    chk(done == 1'b1, "R7 done two cycles after last op", done, 1);
    chk(fail == x_fail, "R6 fail flag", fail, x_fail);
    chk(pass == (!x_fail), "R7 pass", pass, !x_fail);
    if (x_fail) begin
      chk(int'(fail_addr) == x_faddr, "R6 fail address", fail_addr, x_faddr);
      chk(int'(fail_elem) == x_felem, "R6 fail element", fail_elem, x_felem);
      chk(fail_mask == x_fmask, "R5 R6 fail mask", fail_mask, x_fmask);
    end
    chk(fl_ok == int'(x_fail), "R6 scenario intent", x_fail, fl_ok);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(done && !mem_we && !mem_re, "R8 quiet while done",
          {done, mem_we, mem_re}, 3'b100);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 2; f++) begin
      f_en[f] = 1'b0; f_addr[f] = 0; f_bit[f] = 0; f_type[f] = 0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mem_we && !mem_re && mem_addr == '0 && mem_wdata == '0, "R10 port at reset",
        {mem_we, mem_re, mem_addr, mem_wdata}, 0);
    chk(!done && !pass && !fail && fail_addr == '0 && fail_elem == '0 && fail_mask == '0,
        "R10 verdict at reset", {done, pass, fail}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!mem_we && !mem_re && !done, "R10 idle after reset", {mem_we, mem_re, done}, 0);

    // clean run
    run_test(1'b0, 0);

    // stuck-at-1 bit 3 at address 5: first seen in element 1
    f_en[0] = 1'b1; f_addr[0] = 5; f_bit[0] = 3; f_type[0] = 1;
    run_test(1'b1, 1);
    chk(fail_elem == 3'd1 && fail_addr == 5, "R6 stuck-at-1 element 1",
        {fail_elem, fail_addr}, {3'd1, 5'd5});

    // two faults: stuck-at-1 at 9 bit 7 precedes stuck-at-0 at 20 bit 0
    f_addr[0] = 9; f_bit[0] = 7; f_type[0] = 1;
    f_en[1] = 1'b1; f_addr[1] = 20; f_bit[1] = 0; f_type[1] = 0;
    run_test(1'b0, 1);
    chk(fail_addr == 9 && fail_mask == 8'h80, "R6 only first fault kept",
        {fail_addr, fail_mask}, {5'd9, 8'h80});

    // cell that cannot fall: first seen on descending element 3
    f_en[1] = 1'b0;
    f_addr[0] = 26; f_bit[0] = 2; f_type[0] = 2;
    run_test(1'b0, 1);
    chk(fail_elem == 3'd3 && fail_mask == 8'h04, "R6 descending element fault",
        {fail_elem, fail_mask}, {3'd3, 8'h04});

    // R9 rerun without reset, fault removed
    f_en[0] = 1'b0;
    run_test(1'b0, 0);
    chk(pass && !fail, "R9 rerun passes", {pass, fail}, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule